// File: doc/BRIEF.md
# Seven-Best Candidate Keeper for Block-Matching Motion Search

This block keeps a running list of the seven best (lowest-cost) candidate positions seen during a motion search, each with its motion vector. One candidate arrives per cycle. Subsampled distortion values come from an upstream stage, and the vectors of the seven survivors go downstream to a full-distortion stage.

The block does not sort. Each cycle it takes the largest of the seven stored costs and the incoming cost. If a stored entry holds that largest value and is strictly worse than the newcomer, that one entry is overwritten. Equality flags mark every stored entry that matches the largest value, and a priority stage lets only the lowest-numbered flagged slot be written. Cycles without a valid candidate are masked to the all-ones cost, so they can never displace a stored entry.

A clear pulse at the start of each macroblock reloads every slot with the all-ones cost and a zero vector. A finish pulse on the last candidate raises a done strobe one cycle later. In that cycle the seven vectors on the output are final.

Top module: `ssad_keep_top`

## Requirements
- R1: After reset every slot holds cost all-ones and a zero vector, `mv_o` is all zeros and `done_o` is low.
- R2: `clr_i` high at a clock edge reloads every slot with cost all-ones and a zero vector, and takes priority over any candidate in that cycle.
- R3: A valid candidate whose cost is strictly below the largest stored cost replaces exactly one slot that holds that largest cost.
- R4: When several slots share the largest stored cost, the slot with the lowest index is the one replaced.
- R5: A valid candidate whose cost is greater than or equal to every stored cost changes no slot.
- R6: A cycle with `vld_i` low changes no slot, whatever value `cost_i` carries.
- R7: The replaced slot loads both the new cost and the new vector. Slot k's vector appears on `mv_o[12k+11:12k]`, with the x component in the upper six bits and the y component in the lower six, both two's complement.
- R8: `done_o` is high for exactly the cycle after a cycle with `fin_i` high and `clr_i` low. In that cycle `mv_o` includes the update made by the finishing candidate.
- R9: After any sequence of candidates since the last clear, the stored costs are the seven smallest valid costs seen, padded with all-ones entries. Ties are broken as set out in R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Reload all slots for a new macroblock |
| vld_i | input | 1 | Candidate on `cost_i`/`mvx_i`/`mvy_i` is valid |
| cost_i | input | 16 | Subsampled distortion of the candidate |
| mvx_i | input | 6 | Candidate horizontal displacement, signed |
| mvy_i | input | 6 | Candidate vertical displacement, signed |
| fin_i | input | 1 | Marks the last candidate of the search |
| mv_o | output | 84 | Seven stored vectors, slot 0 in the low bits |
| done_o | output | 1 | Vectors on `mv_o` are final |

## Verification
The assertions assume that `clr_i`, `vld_i` and `fin_i` are well-defined binary levels at every clock edge once reset is released. They also assume that `fin_i` is never raised in the same cycle as `clr_i` when a done strobe is expected. The stimulus drives every input on the falling edge from a seeded generator, so all inputs are stable and known at each rising edge. It raises `fin_i` only outside clear cycles. Candidate costs are drawn from a narrow range so that ties with the stored maximum and among stored slots occur often.

// File: rtl/ssad_keep_pkg.sv
package ssad_keep_pkg;
  parameter int unsigned SLOTS  = 7;
  parameter int unsigned COST_W = 16;
  parameter int unsigned MVC_W  = 6;
  localparam int unsigned MV_W  = 2 * MVC_W;
endpackage

// File: rtl/ssad_max_tree.sv
module ssad_max_tree #(
  parameter int unsigned N = 8,
  parameter int unsigned W = 16
) (
  input  logic [N*W-1:0] vals_i,
  output logic [W-1:0]   max_o
);
  localparam int unsigned LG = (N > 1) ? $clog2(N) : 1;
  localparam int unsigned P  = 1 << LG;

  logic [W-1:0] node [1:2*P-1];

  for (genvar l = 0; l < P; l++) begin : g_leaf
    if (l < N) begin : g_real
      assign node[P+l] = vals_i[l*W +: W];
    end else begin : g_pad
      assign node[P+l] = '0;
    end
  end

  for (genvar i = 1; i < P; i++) begin : g_node
    assign node[i] = (node[2*i] >= node[2*i+1]) ? node[2*i] : node[2*i+1];
  end

  assign max_o = node[1];
endmodule

// File: rtl/ssad_pick_first.sv
module ssad_pick_first #(
  parameter int unsigned N = 7
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt_o = '0;
    for (int k = 0; k < N; k++) begin
      if (req_i[k] && !taken) begin
        gnt_o[k] = 1'b1;
        taken    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ssad_slot.sv
module ssad_slot #(
  parameter int unsigned COST_W = 16,
  parameter int unsigned MV_W   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [COST_W-1:0] cost_i,
  input  logic [MV_W-1:0]   mv_i,
  output logic [COST_W-1:0] cost_o,
  output logic [MV_W-1:0]   mv_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cost_o <= '1;
      mv_o   <= '0;
    end else if (clr_i) begin
      cost_o <= '1;
      mv_o   <= '0;
    end else if (load_i) begin
      cost_o <= cost_i;
      mv_o   <= mv_i;
    end
  end
endmodule

// File: rtl/ssad_keep_top.sv
module ssad_keep_top
  import ssad_keep_pkg::*;
#(
  parameter int unsigned SLOTS_P  = SLOTS,
  parameter int unsigned COST_WP  = COST_W,
  parameter int unsigned MVC_WP   = MVC_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      vld_i,
  input  logic [COST_WP-1:0]        cost_i,
  input  logic [MVC_WP-1:0]         mvx_i,
  input  logic [MVC_WP-1:0]         mvy_i,
  input  logic                      fin_i,
  output logic [SLOTS_P*2*MVC_WP-1:0] mv_o,
  output logic                      done_o
);
  localparam int unsigned VW = 2 * MVC_WP;
  localparam int unsigned NT = SLOTS_P + 1;

  logic [COST_WP-1:0]         cost_in;
  logic [SLOTS_P*COST_WP-1:0] cost_flat;
  logic [NT*COST_WP-1:0]      tree_in;
  logic [COST_WP-1:0]         cost_max;
  logic [SLOTS_P-1:0]         eq_flag;
  logic [SLOTS_P-1:0]         rep_oh;
  logic                       evict;

  // invalid cycles present the sentinel so they can never win
  assign cost_in = vld_i ? cost_i : '1;
  assign tree_in = {cost_in, cost_flat};

  ssad_max_tree #(.N(NT), .W(COST_WP)) i_max (
    .vals_i (tree_in),
    .max_o  (cost_max)
  );

  for (genvar k = 0; k < SLOTS_P; k++) begin : g_eq
    assign eq_flag[k] = (cost_flat[k*COST_WP +: COST_WP] == cost_max);
  end

  // a newcomer tied with the maximum is not an improvement
  assign evict = (cost_in != cost_max);

  ssad_pick_first #(.N(SLOTS_P)) i_pick (
    .req_i (eq_flag & {SLOTS_P{evict}}),
    .gnt_o (rep_oh)
  );

  for (genvar k = 0; k < SLOTS_P; k++) begin : g_slot
    ssad_slot #(.COST_W(COST_WP), .MV_W(VW)) i_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .load_i (rep_oh[k]),
      .cost_i (cost_in),
      .mv_i   ({mvx_i, mvy_i}),
      .cost_o (cost_flat[k*COST_WP +: COST_WP]),
      .mv_o   (mv_o[k*VW +: VW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_o <= 1'b0;
    else         done_o <= fin_i && !clr_i;
  end
endmodule

// File: rtl/ssad_keep_chk.sv
module ssad_keep_chk #(
  parameter int unsigned SLOTS_P = 7,
  parameter int unsigned COST_WP = 16,
  parameter int unsigned MVC_WP  = 6
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        clr_i,
  input logic                        vld_i,
  input logic [COST_WP-1:0]          cost_i,
  input logic                        fin_i,
  input logic [SLOTS_P*2*MVC_WP-1:0] mv_o,
  input logic                        done_o,
  input logic [SLOTS_P-1:0]          rep_oh,
  input logic [SLOTS_P*COST_WP-1:0]  cost_flat
);
  logic [COST_WP-1:0] worst;
  always_comb begin
    worst = '0;
    for (int k = 0; k < SLOTS_P; k++)
      if (cost_flat[k*COST_WP +: COST_WP] > worst) worst = cost_flat[k*COST_WP +: COST_WP];
  end

  p_single_winner_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rep_oh));

  p_clear_sentinel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (&cost_flat) && (mv_o == '0));

  p_invalid_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !clr_i) |=> $stable(cost_flat) && $stable(mv_o));

  p_no_worse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !clr_i && cost_i >= worst) |=> $stable(cost_flat) && $stable(mv_o));

  p_better_evicts_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !clr_i && cost_i < worst) |-> $countones(rep_oh) == 1);

  p_done_follows_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_i && !clr_i) |=> done_o);

  p_done_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fin_i && !clr_i) |=> !done_o);
endmodule

bind ssad_keep_top ssad_keep_chk #(
  .SLOTS_P(SLOTS_P), .COST_WP(COST_WP), .MVC_WP(MVC_WP)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .vld_i(vld_i),
  .cost_i(cost_i), .fin_i(fin_i), .mv_o(mv_o), .done_o(done_o),
  .rep_oh(rep_oh), .cost_flat(cost_flat)
);

// File: tb/test_ssad_keep_top.sv
module test_ssad_keep_top;
  localparam int S = 7;
  localparam int CW = 16;
  localparam int VW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, vld = 1'b0, fin = 1'b0;
  logic [CW-1:0] cost = '0;
  logic [5:0] mvx = '0, mvy = '0;
  logic [S*VW-1:0] mv;
  logic done;

  int n_chk = 0, n_fail = 0;
  logic [CW-1:0] m_cost [S];
  logic [VW-1:0] m_mv [S];

  always #5 clk = ~clk;

  ssad_keep_top i_ssad_keep_top (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .vld_i(vld), .cost_i(cost),
    .mvx_i(mvx), .mvy_i(mvy), .fin_i(fin), .mv_o(mv), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input logic [S*VW-1:0] act, input logic [S*VW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [S*VW-1:0] model_flat();
    logic [S*VW-1:0] r;
    for (int k = 0; k < S; k++) r[k*VW +: VW] = m_mv[k];
    return r;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < S; k++) begin m_cost[k] = '1; m_mv[k] = '0; end
  endtask

  task automatic model_apply(input bit v, input logic [CW-1:0] c, input logic [VW-1:0] m);
    logic [CW-1:0] ci, mx;
    ci = v ? c : '1;
    mx = ci;
    for (int k = 0; k < S; k++) if (m_cost[k] > mx) mx = m_cost[k];
    if (mx != ci) begin
      for (int k = 0; k < S; k++) begin
        if (m_cost[k] == mx) begin m_cost[k] = ci; m_mv[k] = m; break; end
      end
    end
  endtask

  task automatic step(input bit c, input bit v, input logic [CW-1:0] cv,
                      input logic [5:0] x, input logic [5:0] y, input bit f, input string req);
    @(negedge clk);
    clr = c; vld = v; cost = cv; mvx = x; mvy = y; fin = f;
    @(posedge clk);
    if (c) model_clear(); else model_apply(v, cv, {x, y});
    #2;
    check(mv === model_flat(), req, mv, model_flat());
    if (f && !c) check(done === 1'b1, "R8 done", {83'd0, done}, {83'd0, 1'b1});
    else         check(done === 1'b0, "R8 quiet", {83'd0, done}, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [S*VW-1:0] snap;
    seed = 32'd20240611;
    void'($urandom(seed));
    model_clear();
    repeat (3) @(posedge clk);
    #2;
    check(mv === '0 && done === 1'b0, "R1 reset", mv, '0);
    @(negedge clk); rst_n = 1'b1;

    // R4: all slots equal after clear, so slots fill from index 0 upward
    step(1, 0, 0, 0, 0, 0, "R2 clear");
    step(0, 1, 16'd500, 6'd1, 6'd2, 0, "R4 R7 first fills slot0");
    check(mv[11:0] === {6'd1, 6'd2}, "R7 slot0 vector", mv, model_flat());
    step(0, 1, 16'd400, 6'h3f, 6'd3, 0, "R4 second fills slot1");
    check(mv[23:12] === {6'h3f, 6'd3}, "R4 slot1 vector", mv, model_flat());
    for (int k = 0; k < 5; k++) step(0, 1, 16'd100 + 16'(k), 6'(k), 6'(k), 0, "R3 fill");
    snap = mv;
    // R6: invalid small cost leaves everything
    step(0, 0, 16'd1, 6'd9, 6'd9, 0, "R6 invalid");
    check(mv === snap, "R6 unchanged", mv, snap);
    // R5: larger and equal to max both ignored
    step(0, 1, 16'd600, 6'd7, 6'd7, 0, "R5 larger");
    step(0, 1, 16'd500, 6'd7, 6'd7, 0, "R5 tie with max");
    check(mv === snap, "R5 unchanged", mv, snap);
    // R3: smaller than max evicts slot0 (cost 500)
    step(0, 1, 16'd450, 6'd5, 6'd4, 0, "R3 evict max");
    check(mv[11:0] === {6'd5, 6'd4}, "R3 slot0 replaced", mv, model_flat());
    // R2: clear has priority over a valid candidate
    step(1, 1, 16'd2, 6'd1, 6'd1, 0, "R2 clear priority");
    check(mv === '0, "R2 zeroed", mv, '0);

    // R9: random blocks with narrow cost range to force ties
    for (int b = 0; b < 20; b++) begin
      step(1, 0, 0, 0, 0, 0, "R2 block clear");
      for (int i = 0; i < 60; i++) begin
        step(0, ($urandom % 5) != 0, 16'($urandom % 24), 6'($urandom), 6'($urandom),
             i == 59, "R9 random");
      end
      step(0, 0, 0, 0, 0, 0, "R8 after done");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule